// File: doc/BRIEF.md
# Existence-Vector Relation Holder

This block stores one finite relation as a flat vector of membership flags, one flag per possible tuple. Atoms come from a domain whose size is a power of two. The tuple's position in the vector is the concatenation of its atom indices. The relation arrives whole on a wide load input. It is taken in on a start request qualified by a valid strobe.

A four-state controller moves through invalid, productive, done and idle. It ensures that downstream logic only sees answers once the loaded relation has settled. While the controller is in done, the block answers three questions and raises a validity flag:

- whether the queried tuple is present;
- how many tuples the relation holds;
- whether the loaded contents obey the packing rule.

The packing rule says that every member sits below every non-member. The count comes from a priority encoder on the highest set flag, which is correct only when that rule holds.

Top module: `rel_exist_machine`

## Requirements
- R1: While reset is low at a clock edge, and after it, until a load is accepted, `valid_o`, `member_o`, `pred_o` and `card_o` are all zero.
- R2: `start_i` and `valid_i` both high at an edge in invalid or idle state captures `load_vec_i`. After that edge the block is productive with `valid_o` low. After the next edge it is done with `valid_o` high.
- R3: `start_i` high with `valid_i` low, in invalid or idle state, starts nothing: `valid_o` stays low.
- R4: In done, the block stays done while `start_i` is high. After an edge with `start_i` low, it is idle and `valid_o` is low.
- R5: In done, `member_o` equals bit `query_idx_i` of the captured vector. Atom k of the tuple occupies bits [k*log2(SCOPE) +: log2(SCOPE)] of the index, with atom 0 least significant.
- R6: In done, `card_o` equals one plus the position of the highest set flag, or zero when no flag is set. A full vector gives SCOPE**ARITY.
- R7: In done, `pred_o` is high exactly when no set flag lies above a clear flag.
- R8: In every state other than done, `member_o`, `card_o` and `pred_o` are zero.
- R9: A load accepted from idle replaces the whole stored vector.
- R10: `load_vec_i` has no effect except at an accepting edge.
- R11: Reset taken in done returns the block to invalid with all outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to produce; held high to stay done |
| valid_i | input | 1 | Qualifies `load_vec_i` for capture |
| load_vec_i | input | SCOPE**ARITY | Membership flags to capture |
| query_idx_i | input | log2(SCOPE)*ARITY | Concatenated atom indices of the queried tuple |
| pred_o | output | 1 | Packing rule holds (done only) |
| member_o | output | 1 | Queried tuple is present (done only) |
| card_o | output | log2(SCOPE)*ARITY+1 | Relation cardinality (done only) |
| valid_o | output | 1 | Answers are usable |

## Verification
A controller stuck in the wrong state shows at the ports within one or two edges of a start request. `valid_o` either fails to rise on the second edge after acceptance or rises a cycle early. A stored vector that drifts, or that takes in load data outside an accepting edge, changes `member_o` and `card_o` for an index whose expected value the bench derives from the last accepted vector. An error in the encoder appears as a wrong count for vectors whose highest flag sits at the boundaries: empty, full, or non-packed with a gap below the top bit.

// File: rtl/rel_exist_pkg.sv
// Package: shared controller state encoding for the relation holder.
// Assumes: nothing beyond standard SystemVerilog.
package rel_exist_pkg;
    typedef enum logic [1:0] {
        ST_INVALID    = 2'd0,
        ST_PRODUCTIVE = 2'd1,
        ST_DONE       = 2'd2,
        ST_IDLE       = 2'd3
    } rex_state_t;
endpackage

// File: rtl/rex_index.sv
// Module: rex_index
// Splits the concatenated query index into atom fields and rebuilds
// the flat tuple position by shifting each field into place.
// Assumes: the atom domain is a power of two, so fields never overflow.
module rex_index #(
    parameter int ATOM_W = 3,
    parameter int ARITY  = 2,
    localparam int IDX_W = ATOM_W * ARITY
) (
    input  logic [IDX_W-1:0] query_idx,
    output logic [IDX_W-1:0] tuple_pos
);
    logic [ARITY-1:0][ATOM_W-1:0] atoms;
    logic [ARITY-1:0][IDX_W-1:0]  placed;

    // one field extractor and shifter per tuple position
    for (genvar k = 0; k < ARITY; k++) begin : g_field
        assign atoms[k]  = query_idx[k*ATOM_W +: ATOM_W];
        assign placed[k] = IDX_W'(atoms[k]) << (k * ATOM_W);
    end

    // merge the shifted fields into one position
    always_comb begin
        tuple_pos = '0;
        for (int k = 0; k < ARITY; k++) tuple_pos = tuple_pos | placed[k];
    end
endmodule

// File: rtl/rex_store.sv
// Module: rex_store
// Holds the existence vector; captures it whole on load_en and reads
// one flag at the given tuple position.
// Assumes: rd_pos always lies inside the vector (power-of-two depth).
module rex_store #(
    parameter int IDX_W = 6,
    localparam int TUPLES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [TUPLES-1:0] load_vec,
    input  logic [IDX_W-1:0]  rd_pos,
    output logic [TUPLES-1:0] vec,
    output logic              rd_bit
);
    // capture the relation on an accepted load, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)       vec <= '0;
        else if (load_en) vec <= load_vec;
    end

    // single-flag read port
    assign rd_bit = vec[rd_pos];

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !load_en |=> $stable(vec)); // R10
endmodule

// File: rtl/rex_prio.sv
// Module: rex_prio
// Priority encoder on the highest set flag giving the cardinality, and a
// check that no set flag lies above a clear one.
// Assumes: the count is meaningful only when packed is high.
module rex_prio #(
    parameter int IDX_W = 6,
    localparam int TUPLES = 1 << IDX_W,
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic [TUPLES-1:0] vec,
    output logic [CNT_W-1:0]  card,
    output logic              packed_ok
);
    // highest set flag wins; its position plus one is the count
    always_comb begin
        card = '0;
        for (int i = 0; i < TUPLES; i++) begin
            if (vec[i]) card = CNT_W'(i + 1);
        end
    end

    // scan upward; a set flag after any clear flag breaks packing
    always_comb begin
        logic gap;
        gap       = 1'b0;
        packed_ok = 1'b1;
        for (int i = 0; i < TUPLES; i++) begin
            if (!vec[i])  gap       = 1'b1;
            else if (gap) packed_ok = 1'b0;
        end
    end
endmodule

// File: rtl/rex_ctrl.sv
// Module: rex_ctrl
// Four-state controller: invalid -> productive -> done -> idle, with a
// qualified start re-entering productive from invalid or idle.
// Assumes: synchronous active-low reset.
module rex_ctrl
    import rel_exist_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       valid_in,
    output rex_state_t state,
    output logic       load_en
);
    rex_state_t nxt;
    logic       accept;
    logic       ready;

    assign accept  = start && valid_in;
    assign ready   = (state == ST_INVALID) || (state == ST_IDLE);
    assign load_en = ready && accept;

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_INVALID, ST_IDLE: if (accept) nxt = ST_PRODUCTIVE;
            ST_PRODUCTIVE:       nxt = ST_DONE;
            ST_DONE:             if (!start) nxt = ST_IDLE;
            default:             nxt = ST_INVALID;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_INVALID;
        else        state <= nxt;
    end

    AST_RESET_INVALID: assert property (@(posedge clk) !rst_n |=> state == ST_INVALID); // R11
    AST_PROD_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n) state == ST_PRODUCTIVE |=> state == ST_DONE); // R2
    AST_NO_START_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n) (ready && !accept) |=> state == $past(state)); // R3
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_DONE && start) |=> state == ST_DONE); // R4
endmodule

// File: rtl/rel_exist_machine.sv
// Module: rel_exist_machine (top)
// Stores a relation as existence flags and answers membership,
// cardinality and packing queries once the controller reaches done.
// Assumes: SCOPE is a power of two up to 32, ARITY is 1 or 2.
module rel_exist_machine
    import rel_exist_pkg::*;
#(
    parameter int SCOPE = 8,
    parameter int ARITY = 2,
    localparam int ATOM_W = $clog2(SCOPE),
    localparam int IDX_W  = ATOM_W * ARITY,
    localparam int TUPLES = 1 << IDX_W,
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [TUPLES-1:0] load_vec_i,
    input  logic [IDX_W-1:0]  query_idx_i,
    output logic              pred_o,
    output logic              member_o,
    output logic [CNT_W-1:0]  card_o,
    output logic              valid_o
);
    rex_state_t        state;
    logic              load_en;
    logic [IDX_W-1:0]  tuple_pos;
    logic [TUPLES-1:0] vec;
    logic              rd_bit;
    logic [CNT_W-1:0]  card;
    logic              packed_ok;
    logic              done;

    rex_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .valid_in (valid_i),
        .state    (state),
        .load_en  (load_en)
    );

    rex_index #(.ATOM_W(ATOM_W), .ARITY(ARITY)) u_index (
        .query_idx (query_idx_i),
        .tuple_pos (tuple_pos)
    );

    rex_store #(.IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_vec (load_vec_i),
        .rd_pos   (tuple_pos),
        .vec      (vec),
        .rd_bit   (rd_bit)
    );

    rex_prio #(.IDX_W(IDX_W)) u_prio (
        .vec       (vec),
        .card      (card),
        .packed_ok (packed_ok)
    );

    // answers are released only in done
    assign done     = (state == ST_DONE);
    assign valid_o  = done;
    assign member_o = done & rd_bit;
    assign pred_o   = done & packed_ok;
    assign card_o   = done ? card : '0;

    AST_CARD_MATCH: assert property (@(posedge clk) disable iff (!rst_n) packed_ok |-> card == CNT_W'($countones(vec))); // R6
    AST_CARD_BOUND: assert property (@(posedge clk) disable iff (!rst_n) card <= CNT_W'(TUPLES)); // R6
    AST_VALID_AFTER_PROD: assert property (@(posedge clk) disable iff (!rst_n) $rose(valid_o) |-> $past(state) == ST_PRODUCTIVE); // R2
endmodule

// File: tb/rel_exist_machine_bench.sv
`timescale 1ns/1ps
module rel_exist_machine_bench;
    localparam int SCOPE  = 4;
    localparam int ARITY  = 2;
    localparam int IDX_W  = 4;
    localparam int TUPLES = 16;
    localparam int CNT_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              valid_i = 1'b0;
    logic [TUPLES-1:0] load_vec_i = '0;
    logic [IDX_W-1:0]  query_idx_i = '0;
    logic              pred_o, member_o, valid_o;
    logic [CNT_W-1:0]  card_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    rel_exist_machine #(.SCOPE(SCOPE), .ARITY(ARITY)) u_rel_exist_machine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .load_vec_i(load_vec_i), .query_idx_i(query_idx_i),
        .pred_o(pred_o), .member_o(member_o), .card_o(card_o), .valid_o(valid_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_card(input logic [TUPLES-1:0] v);
        int c = 0;
        for (int i = 0; i < TUPLES; i++) if (v[i]) c = i + 1;
        return c;
    endfunction

    function automatic int ref_packed(input logic [TUPLES-1:0] v);
        return (ref_card(v) == $countones(v)) ? 1 : 0;
    endfunction

    task automatic check_idle_outputs(input string req);
        check({req, " valid"}, int'(valid_o), 0);
        check({req, " member"}, int'(member_o), 0);
        check({req, " pred"}, int'(pred_o), 0);
        check({req, " card"}, int'(card_o), 0);
    endtask

    // accept a load, check productive then done, scramble load data after
    task automatic load_and_wait(input logic [TUPLES-1:0] v);
        @(negedge clk); start_i = 1'b1; valid_i = 1'b1; load_vec_i = v;
        @(negedge clk); valid_i = 1'b0; load_vec_i = ~v;
        check("R2 productive valid low", int'(valid_o), 0);
        check("R8 productive card zero", int'(card_o), 0);
        @(negedge clk);
        check("R2 done valid high", int'(valid_o), 1);
    endtask

    task automatic check_answers(input string req, input logic [TUPLES-1:0] v);
        check({req, " R6 card"}, int'(card_o), ref_card(v));
        check({req, " R7 pred"}, int'(pred_o), ref_packed(v));
        for (int a1 = 0; a1 < SCOPE; a1++) begin
            for (int a0 = 0; a0 < SCOPE; a0++) begin
                query_idx_i = IDX_W'((a1 << 2) | a0);
                #0.1;
                check({req, " R5 member"}, int'(member_o), int'(v[a1*SCOPE + a0]));
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; start_i = 1'b1; valid_i = 1'b1; load_vec_i = '1;
        repeat (2) @(negedge clk);
        check_idle_outputs("R1 in reset");
        start_i = 1'b0; valid_i = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check_idle_outputs("R1 after reset");
    endtask

    task automatic t_start_without_valid;
        @(negedge clk); start_i = 1'b1; valid_i = 1'b0; load_vec_i = 16'hFFFF;
        repeat (3) begin
            @(negedge clk);
            check("R3 valid stays low", int'(valid_o), 0);
        end
        start_i = 1'b0;
    endtask

    task automatic t_packed_load;
        logic [TUPLES-1:0] v = 16'h00FF;
        load_and_wait(v);
        check_answers("packed", v);
        query_idx_i = 4'b0001 << 2 | 4'd3; #0.1;
        check("R5 atom1=1 atom0=3", int'(member_o), 1);
        // hold start, keep scrambling load data: still done, vector unchanged
        repeat (3) begin
            @(negedge clk); load_vec_i = 16'h5A5A; valid_i = 1'b1;
            check("R4 stays done", int'(valid_o), 1);
            check("R10 card unchanged", int'(card_o), 8);
        end
        valid_i = 1'b0;
    endtask

    task automatic t_drop_start;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        check_idle_outputs("R4 R8 idle");
        query_idx_i = 4'd0; #0.1;
        check("R8 idle member", int'(member_o), 0);
    endtask

    task automatic t_reload(input logic [TUPLES-1:0] v, input string tag);
        load_and_wait(v);
        check_answers({"R9 ", tag}, v);
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_from_done;
        load_and_wait(16'h0007);
        check("R11 pre done", int'(valid_o), 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; start_i = 1'b0;
        check_idle_outputs("R11 after reset");
        @(negedge clk);
        check_idle_outputs("R11 invalid");
    endtask

    initial begin
        t_reset();
        t_start_without_valid();
        t_packed_load();
        t_drop_start();
        t_reload(16'h0A01, "gapped");
        t_reload(16'h0000, "empty");
        t_reload(16'hFFFF, "full");
        t_reload(16'h8000, "top only");
        t_reset_from_done();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule